// File: doc/BRIEF.md
# Inverted Open-Drain I/O Port Bank

This block holds 48 general-purpose pins, arranged as six byte-wide ports, each pin being pulled low or left to float high through an external pull-up. No direction register exists. A pin set to pull low behaves as an output at logic 0. A pin that is released reads back whatever level the outside world (or the pull-up) puts on it, so it behaves as an input. The host reaches every port with a byte write strobe and a combinational byte read addressed by a 4-bit offset. All data seen by the host is the inverse of the pin level.

Writing a 1 into a bit sets its pull-low latch and writing 0 clears it. The pad pins pass through a two-stage synchronizer before they are presented on the read path. A six-bit lock vector, produced outside this block, turns individual ports read-only.

Top module: `odio_bank`

## Requirements
- R1: After reset every pull-low latch is 0, so `pad_oe` is all zeros and every line floats high; writing 0x00 to all six ports returns the bank to the same state.
- R2: A write with `wr_en` high, `addr` in 0x0..0x5 and the port's lock bit clear loads `wdata` into that port's latch at that clock edge; bit b of port p drives `pad_oe[8*p+b]` from the next cycle on.
- R3: `pad_out` is 0 on every line at all times; a line is pulled low exactly when its `pad_oe` bit is 1.
- R4: While `port_lock[p]` is 1, writes to port p leave its latch unchanged; writes to other unlocked ports still take effect.
- R5: A write to any address in 0x6..0xF changes no latch.
- R6: Reading port p returns the bitwise inverse of `pad_in[8*p+7:8*p]` as sampled two clock edges earlier (1 = pin low, 0 = pin high); a change on a pad is not visible after one edge and is visible after two.
- R7: A read of an address in 0x6..0xF returns 0x00.
- R8: A write to one port leaves the latches of the other five ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte offset for read and write |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data, 1 = pull line low |
| rdata | output | 8 | Read data, inverted pin level |
| port_lock | input | 6 | Per-port write-protect flags, bit p guards port p |
| pad_in | input | 48 | Sampled pin levels |
| pad_out | output | 48 | Driven pin value (always 0) |
| pad_oe | output | 48 | Per-pin drive enable, 1 = pull low |

## Verification
The embedded properties watch, on every clock, that a write to an unlocked port lands in the latch, that locked ports and unused offsets keep every latch steady, that ports not addressed hold their value, that the drive value stays zero, and that the read path equals the inverted pad level from two edges earlier. Only the bench scenarios show the end-to-end picture: an external device pulling released lines low and that level reaching the read data, the exact cycle a pad change becomes visible, the reset and all-zero release state, and reads of unused offsets returning zero.

// File: rtl/odio_bank.sv
module odio_bank #(
  parameter int NPORT = 6,
  parameter int PW    = 8,
  parameter int AW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                wr_en,
  input  logic [PW-1:0]       wdata,
  output logic [PW-1:0]       rdata,
  input  logic [NPORT-1:0]    port_lock,
  input  logic [NPORT*PW-1:0] pad_in,
  output logic [NPORT*PW-1:0] pad_out,
  output logic [NPORT*PW-1:0] pad_oe
);
  localparam int NLINE = NPORT * PW;

  logic [NLINE-1:0] latch_q;
  logic [NLINE-1:0] meta_q;
  logic [NLINE-1:0] sync_q;

  assign pad_oe  = latch_q;
  assign pad_out = '0;

  always_ff @(posedge clk) begin
    meta_q <= pad_in;
    sync_q <= meta_q;
  end

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_port
      logic hit;
      assign hit = wr_en && (addr == AW'(p)) && !port_lock[p];

      always_ff @(posedge clk) begin
        if (!rst_n)   latch_q[p*PW +: PW] <= '0;
        else if (hit) latch_q[p*PW +: PW] <= wdata;
      end

      a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(p) && !port_lock[p]) |=> pad_oe[p*PW +: PW] == $past(wdata));

      a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(p) && port_lock[p]) |=> $stable(pad_oe[p*PW +: PW]));

      a_r8_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == AW'(p)) |=> $stable(pad_oe[p*PW +: PW]));

      a_r6_read_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(p)) |-> rdata == ~$past(pad_in[p*PW +: PW], 2));
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NPORT; i++)
      if (addr == AW'(i)) rdata = ~sync_q[i*PW +: PW];
  end

  a_r5_bad_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= AW'(NPORT)) |=> $stable(pad_oe));

  a_r7_bad_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= AW'(NPORT)) |-> rdata == '0);

  a_r3_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
    pad_out == '0);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> pad_oe == '0);
endmodule

// File: tb/odio_bank_test.sv
module odio_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  addr = '0;
  logic        wr_en = 0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [5:0]  port_lock = '0;
  logic [47:0] ext = '1;
  logic [47:0] pad_in;
  logic [47:0] pad_out;
  logic [47:0] pad_oe;

  always #5 clk = ~clk;

  assign pad_in = ~pad_oe & ext;

  odio_bank uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .port_lock(port_lock), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct {
    string       tag;
    int          kind;
    int          idx;
    logic [47:0] exp;
  } item_t;

  item_t q[$];
  logic  mon_go = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  always @(negedge clk) begin
    if (mon_go && q.size() > 0) begin
      item_t it;
      logic [47:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {40'd0, rdata};
        1: act = {40'd0, pad_oe[it.idx*8 +: 8]};
        default: act = pad_out;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(input string tag, input int kind, input int idx,
                             input logic [47:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.idx = idx; it.exp = exp;
    @(posedge clk); #1;
    if (kind == 0) addr = idx[3:0];
    q.push_back(it);
    mon_go = 1;
    @(negedge clk); #1;
    mon_go = 0;
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a[3:0]; wdata = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int p = 0; p < 6; p++) expect_item("R1 reset oe", 1, p, 48'h0);
    expect_item("R3 pad_out zero", 2, 0, 48'h0);
    settle();
    expect_item("R6 released reads 0", 0, 0, 48'h00);

    do_write(0, 8'hA5);
    expect_item("R2 port0 oe", 1, 0, 48'hA5);
    expect_item("R8 port1 untouched", 1, 1, 48'h00);
    settle();
    expect_item("R6 port0 read", 0, 0, 48'hA5);
    expect_item("R3 pad_out zero while driving", 2, 0, 48'h0);

    do_write(5, 8'hFF);
    expect_item("R2 port5 oe", 1, 5, 48'hFF);
    expect_item("R8 port0 kept", 1, 0, 48'hA5);
    settle();
    expect_item("R6 port5 read", 0, 5, 48'hFF);

    ext[31:24] = 8'hF0;
    settle();
    expect_item("R6 external pull low", 0, 3, 48'h0F);

    @(posedge clk); #1 ext[39:32] = 8'h00;
    expect_item("R6 not visible after one edge", 0, 4, 48'h00);
    expect_item("R6 visible after two edges", 0, 4, 48'hFF);

    port_lock = 6'b000100;
    do_write(2, 8'h3C);
    expect_item("R4 locked port2 unchanged", 1, 2, 48'h00);
    do_write(1, 8'h11);
    expect_item("R4 unlocked port1 written", 1, 1, 48'h11);
    port_lock = '0;
    do_write(2, 8'h3C);
    expect_item("R4 port2 after unlock", 1, 2, 48'h3C);

    do_write(6, 8'hFF);
    do_write(15, 8'h77);
    expect_item("R5 port0 after bad addr", 1, 0, 48'hA5);
    expect_item("R5 port1 after bad addr", 1, 1, 48'h11);
    expect_item("R5 port2 after bad addr", 1, 2, 48'h3C);
    expect_item("R5 port3 after bad addr", 1, 3, 48'h00);
    expect_item("R5 port4 after bad addr", 1, 4, 48'h00);
    expect_item("R5 port5 after bad addr", 1, 5, 48'hFF);

    expect_item("R7 addr 7 reads zero", 0, 7, 48'h00);
    expect_item("R7 addr 15 reads zero", 0, 15, 48'h00);

    ext = '1;
    for (int p = 0; p < 6; p++) do_write(p, 8'h00);
    for (int p = 0; p < 6; p++) expect_item("R1 all released", 1, p, 48'h00);
    settle();
    for (int p = 0; p < 6; p++) expect_item("R1 released reads zero", 0, p, 48'h00);

    repeat (2) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule